// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a small field-configurable sum-of-products engine. Each of its product terms can take any input, the complement of any input, or both as literals. Each output combines any chosen set of those terms. Every output also has its own polarity bit, so it can present either the sum or its inverse. Terms are shared among all outputs, so a term used by two functions costs one AND gate rather than two.

The link pattern is held in flip-flops and is written one row at a time through a small register-write port. A plane select bit, a row index, a mask and a write strobe make up that port. A second, independent port returns any stored row, so configuration software can read back what it wrote. The path from `din` to `dout` is purely combinational; only configuration changes wait for a clock edge.

Top module: `pla_array`

## Requirements
- R1: In a term row, mask bit i links input `din[i]` and mask bit N_IN+i links its complement `~din[i]`; both forms of every input are selectable for any term.
- R2: A product term is the logical AND of every literal linked in its row.
- R3: A term row with no bit set evaluates to 0, so it never raises an output.
- R4: A term row that links both `din[i]` and `~din[i]` evaluates to 0 for every input value.
- R5: Output o is the OR of the terms whose bits are set in bits N_TERM-1..0 of its output row, and it follows `din` with no clock edge in the path.
- R6: Bit N_TERM of an output row inverts that output after the OR.
- R7: An output row with no term bit set gives 0 before inversion, and so gives 1 when its inversion bit is set.
- R8: While `rst_n` is low every row is cleared, so readback returns 0 and every output is 0.
- R9: A write with `cfg_we` high stores `cfg_mask` into the row chosen by `cfg_plane` (0 = term rows, 1 = output rows) and `cfg_idx` at the next rising edge; `rd_mask` returns the row chosen by `rd_plane`/`rd_idx`, zero-extended, and still shows the old value before that edge.
- R10: A write whose index is at or above the row count of the chosen plane changes nothing, and readback of such an index returns 0.
- R11: With three inputs A=`din[2]`, B=`din[1]`, C=`din[0]`, three shared terms AB, AC and BC program the functions F1 = AB + AC on `dout[0]` and F2 = AC + BC on `dout[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears every row |
| cfg_we | input | 1 | Write strobe for one configuration row |
| cfg_plane | input | 1 | Plane of the written row: 0 term plane, 1 output plane |
| cfg_idx | input | IW | Row index of the write |
| cfg_mask | input | CW | Link pattern for the written row |
| rd_plane | input | 1 | Plane of the row to read back |
| rd_idx | input | IW | Row index to read back |
| rd_mask | output | CW | Stored link pattern of the selected row, zero-extended |
| din | input | N_IN | Logic inputs |
| dout | output | N_OUT | Logic outputs after polarity |

## Verification
The bench builds the array with three inputs, five terms and three outputs. Three inputs let all eight input patterns be walked exhaustively against the two shared-term functions. The fifth term and third output stay free for the unused-term, contradiction, complement-literal and empty-output cases. A 3-bit index with only five term rows and three output rows leaves indices that point past both planes, so the ignored-write path and the zero readback of missing rows can be reached and observed.

// File: rtl/pla_array.sv
module pla_array #(
  parameter int N_IN   = 3,
  parameter int N_TERM = 5,
  parameter int N_OUT  = 3,
  localparam int LW    = 2 * N_IN,
  localparam int OW    = N_TERM + 1,
  localparam int CW    = (LW > OW) ? LW : OW,
  localparam int TMAX  = (N_TERM > N_OUT) ? N_TERM : N_OUT,
  localparam int IW    = $clog2(TMAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_plane,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [CW-1:0]    cfg_mask,
  input  logic             rd_plane,
  input  logic [IW-1:0]    rd_idx,
  output logic [CW-1:0]    rd_mask,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout
);

  logic [N_TERM-1:0][LW-1:0] and_q;
  logic [N_OUT-1:0][OW-1:0]  or_q;
  logic [LW-1:0]             lit;
  logic [N_TERM-1:0]         term;

  assign lit = {~din, din};

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        and_q[k] <= '0;
      else if (cfg_we && !cfg_plane && cfg_idx == IW'(k))
        and_q[k] <= cfg_mask[LW-1:0];

    assign term[k] = (|and_q[k]) & (&(lit | ~and_q[k]));

    AST_TERM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_plane && cfg_idx == IW'(k)) |=> (and_q[k] == $past(cfg_mask[LW-1:0]))); // R9
    AST_EMPTY_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (and_q[k] == '0) |-> !term[k]); // R3
    AST_CONTRA_TERM: assert property (@(posedge clk) disable iff (!rst_n)
      (|(and_q[k][N_IN-1:0] & and_q[k][LW-1:N_IN])) |-> !term[k]); // R4
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
        or_q[o] <= '0;
      else if (cfg_we && cfg_plane && cfg_idx == IW'(o))
        or_q[o] <= cfg_mask[OW-1:0];

    assign dout[o] = (|(term & or_q[o][N_TERM-1:0])) ^ or_q[o][N_TERM];

    AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_plane && cfg_idx == IW'(o)) |=> (or_q[o] == $past(cfg_mask[OW-1:0]))); // R9
    AST_EMPTY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (or_q[o][N_TERM-1:0] == '0) |-> (dout[o] == or_q[o][N_TERM])); // R7
  end

  always_comb begin
    rd_mask = '0;
    if (!rd_plane) begin
      for (int k = 0; k < N_TERM; k++)
        if (rd_idx == IW'(k)) rd_mask = CW'(and_q[k]);
    end else begin
      for (int o = 0; o < N_OUT; o++)
        if (rd_idx == IW'(o)) rd_mask = CW'(or_q[o]);
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (and_q == '0 && or_q == '0)); // R8
  AST_OOR_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_plane && cfg_idx >= IW'(N_TERM)) |=> $stable(and_q)); // R10
  AST_OOR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_plane && cfg_idx >= IW'(N_OUT)) |=> $stable(or_q)); // R10

endmodule

// File: tb/tb_pla_array.sv
module tb_pla_array;
  localparam int N_IN = 3, N_TERM = 5, N_OUT = 3;
  localparam int CW = 6, IW = 3;

  logic clk = 0, rst_n = 0, cfg_we = 0, cfg_plane = 0, rd_plane = 0;
  logic [IW-1:0] cfg_idx = '0, rd_idx = '0;
  logic [CW-1:0] cfg_mask = '0, rd_mask;
  logic [N_IN-1:0] din = '0;
  logic [N_OUT-1:0] dout;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pla_array #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
    .cfg_idx(cfg_idx), .cfg_mask(cfg_mask), .rd_plane(rd_plane), .rd_idx(rd_idx),
    .rd_mask(rd_mask), .din(din), .dout(dout));

  // {din(A,B,C), expected dout(y2,y1,y0)} for F1 = AB+AC, F2 = AC+BC
  localparam logic [5:0] VEC [8] = '{
    6'b000_000, 6'b001_000, 6'b010_000, 6'b011_010,
    6'b100_000, 6'b101_011, 6'b110_001, 6'b111_011};

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(logic plane, logic [IW-1:0] idx, logic [CW-1:0] m);
    @(negedge clk);
    cfg_we = 1; cfg_plane = plane; cfg_idx = idx; cfg_mask = m;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd(logic plane, logic [IW-1:0] idx, string tag, logic [CW-1:0] exp);
    rd_plane = plane; rd_idx = idx; #1;
    chk(tag, 8'(rd_mask), 8'(exp));
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    din = 3'b111; #1;
    chk("R8 outputs in reset", 8'(dout), 8'h0);
    rd(0, 2, "R8 term readback in reset", '0);
    rst_n = 1;
    @(negedge clk);
    rd(1, 0, "R8 output readback after reset", '0);

    // R9 timing: old value before the edge, new after it
    @(negedge clk);
    cfg_we = 1; cfg_plane = 0; cfg_idx = 0; cfg_mask = 6'b000110;
    rd_plane = 0; rd_idx = 0; #1;
    chk("R9 before edge", 8'(rd_mask), 8'h00);
    @(posedge clk); #1;
    chk("R9 after edge", 8'(rd_mask), 8'h06);
    @(negedge clk); cfg_we = 0;

    wr(0, 1, 6'b000101);            // AC
    wr(0, 2, 6'b000011);            // BC
    wr(1, 0, 6'b000011);            // F1 = T0|T1
    wr(1, 1, 6'b000110);            // F2 = T1|T2
    rd(0, 1, "R9 term readback", 6'b000101);
    rd(1, 1, "R9 output readback", 6'b000110);

    // R11/R5/R2: shared-term functions over every input pattern
    for (int i = 0; i < 8; i++) begin
      din = VEC[i][5:3]; #1;
      chk($sformatf("R11 R5 din=%0d", i), 8'(dout), 8'(VEC[i][2:0]));
    end

    // R3: out2 linked to an empty term stays low
    wr(1, 2, 6'b001000);
    for (int i = 0; i < 8; i++) begin
      din = 3'(i); #1;
      chk("R3 empty term", 8'(dout[2]), 8'h0);
    end

    // R4: term3 = A & ~A & B never fires
    wr(0, 3, 6'b100110);
    for (int i = 0; i < 8; i++) begin
      din = 3'(i); #1;
      chk("R4 contradictory term", 8'(dout[2]), 8'h0);
    end

    // R1: term4 = ~A & ~C drives out2
    wr(0, 4, 6'b101000);
    wr(1, 2, 6'b010000);
    for (int i = 0; i < 8; i++) begin
      din = 3'(i); #1;
      chk("R1 complement literals", 8'(dout[2]), 8'((i & 5) == 0));
    end

    // R6: invert F1
    wr(1, 0, 6'b100011);
    for (int i = 0; i < 8; i++) begin
      din = VEC[i][5:3]; #1;
      chk("R6 inverted output", 8'(dout[0]), 8'(!VEC[i][0]));
    end

    // R7: empty output with and without inversion
    wr(1, 2, 6'b000000);
    din = 3'b111; #1;
    chk("R7 empty output", 8'(dout[2]), 8'h0);
    wr(1, 2, 6'b100000);
    din = 3'b010; #1;
    chk("R7 empty output inverted", 8'(dout[2]), 8'h1);

    // R10: out-of-range writes change nothing
    wr(0, 6, 6'b111111);
    wr(1, 5, 6'b111111);
    rd(0, 6, "R10 missing term row", '0);
    rd(1, 5, "R10 missing output row", '0);
    rd(0, 4, "R10 term row kept", 6'b101000);
    rd(1, 1, "R10 output row kept", 6'b000110);
    for (int i = 0; i < 8; i++) begin
      din = VEC[i][5:3]; #1;
      chk("R10 outputs unchanged", 8'(dout), 8'({1'b1, VEC[i][1], !VEC[i][0]}));
    end

    // R8: reset again clears everything
    @(negedge clk); rst_n = 0; #1;
    din = 3'b101; #1;
    chk("R8 outputs after re-reset", 8'(dout), 8'h0);
    rd(1, 0, "R8 readback after re-reset", '0);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule